// File: doc/BRIEF.md
# Branch Target Buffer Next-PC Predictor

This block sits in the fetch stage and chooses the next fetch address in the same cycle that the current fetch address arrives. It looks up a direct-mapped table of tagged entries using only the fetch address, so no decode is needed. Each entry holds a tag taken from the upper address bits, a predicted target, a valid bit and a one-bit kind flag that records whether the entry came from an unconditional jump. On a tag hit the stored target is the next fetch address. On a miss the next address is the sequential one, fetch PC plus 4.

Training comes from the execute stage through a resolve port. Each resolved control transfer brings its own address, its taken outcome, whether it is a jump, its real target, and the next address that was predicted for it at fetch. The block compares the real next address with the predicted one and raises a mispredict flag in the same cycle, so the pipeline can kill younger instructions. At the end of that cycle a taken branch or a jump fills or overwrites its entry. A not-taken branch that still owns an entry clears that entry. Nothing else writes the table.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset clears every valid bit. After reset, every fetch address misses.
- R2: On a miss, fetch_hit is 0, fetch_is_jump is 0 and fetch_next_pc equals fetch_pc + 4.
- R3: On a hit, fetch_hit is 1 and fetch_next_pc equals the stored target in the same cycle. The decision uses fetch_pc alone: index is fetch_pc[5:2] and tag is fetch_pc[31:6].
- R4: A resolve with res_taken=1 writes a valid entry with the resolved target at the branch's index and tag. A fetch of that address hits from the next cycle on.
- R5: A resolve with res_is_jump=1 allocates an entry even when res_taken is 0.
- R6: A resolve that is neither taken nor a jump, whose address matches a valid entry (same index and tag), clears that entry. Later fetches of that address miss.
- R7: A resolve that is neither taken nor a jump and matches no entry changes no entry. This includes an entry at the same index with a different tag.
- R8: An entry hits only when its stored tag equals fetch_pc[31:6]. An address that aliases to the same index with another tag misses.
- R9: A taken resolve whose address already has an entry overwrites the target in place. The entry stays valid, and the new target is predicted from the next cycle on.
- R10: res_mispredict is 1 exactly when res_valid is 1 and the resolved next address differs from res_pred_next. The resolved next address is res_target if res_taken or res_is_jump is 1, otherwise res_pc + 4.
- R11: fetch_is_jump is 1 on a hit whose entry was last written by a resolve with res_is_jump=1, and 0 otherwise.
- R12: A taken resolve at an index held by another tag evicts the old entry. The old address misses afterwards and the new one hits.
- R13: A table write takes effect at the end of the resolve cycle. A fetch of the same address in that same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Current fetch address |
| fetch_hit | output | 1 | Fetch address matched a valid entry |
| fetch_next_pc | output | 32 | Predicted next fetch address |
| fetch_is_jump | output | 1 | Matched entry was written by a jump |
| res_valid | input | 1 | A resolved control transfer is present |
| res_pc | input | 32 | Address of the resolved instruction |
| res_taken | input | 1 | Resolved branch outcome |
| res_is_jump | input | 1 | Resolved instruction is an unconditional jump |
| res_target | input | 32 | Resolved target address |
| res_pred_next | input | 32 | Next address predicted for it at fetch |
| res_mispredict | output | 1 | Resolved next address differs from the prediction |

## Verification
The bench creates aliasing addresses that share an index but not a tag. A design that compares too few tag bits would then hit on the wrong address, and a design that lets a non-matching not-taken resolve clear an entry would lose the resident one. It runs retargeting, invalidation and eviction in turn and checks the prediction on the very next cycle. A stale target, a lost valid bit or an off-by-one write delay each shows up as a wrong next PC. It also fetches an address in the same cycle that it is being written, which catches a write-through that bypasses the registered table. It checks a jump that resolves with res_taken low, which catches a design that allocates only on the taken flag or computes the resolved next address from it alone.

// File: rtl/btb_pkg.sv
package btb_pkg;
    parameter int PC_W    = 32;
    parameter int ENTRIES = 16;
    parameter int INSN_B  = 4;

    localparam int OFS_W = $clog2(INSN_B);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - OFS_W - IDX_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic valid;
        logic is_jump;
        tag_t tag;
        pc_t  target;
    } entry_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_FILL = 2'd1,
        WR_KILL = 2'd2
    } wr_op_e;

    typedef struct packed {
        wr_op_e op;
        idx_t   idx;
        entry_t data;
    } wr_req_t;

    typedef struct packed {
        logic valid;
        pc_t  pc;
        logic taken;
        logic is_jump;
        pc_t  target;
        pc_t  pred_next;
    } resolve_t;

    function automatic idx_t idx_of(input pc_t pc);
        return pc[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(INSN_B);
    endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  wr_req_t      wr,
    input  idx_t         rd_idx_f,
    input  idx_t         rd_idx_r,
    output entry_t       rd_ent_f,
    output entry_t       rd_ent_r,
    output logic [ENTRIES-1:0] valid_vec
);
    entry_t ent_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        entry_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q.valid <= 1'b0;
            end else if (wr.idx == idx_t'(g)) begin
                case (wr.op)
                    WR_FILL: q       <= wr.data;
                    WR_KILL: q.valid <= 1'b0;
                    default: ;
                endcase
            end
        end
        assign ent_arr[g]   = q;
        assign valid_vec[g] = q.valid;
    end

    assign rd_ent_f = ent_arr[rd_idx_f];
    assign rd_ent_r = ent_arr[rd_idx_r];

    // R4
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.op == WR_FILL) |=> valid_vec[$past(wr.idx)]);

    // R6
    kill_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.op == WR_KILL) |=> !valid_vec[$past(wr.idx)]);

    // R7
    idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.op == WR_NONE) |=> $stable(valid_vec));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  pc_t    pc,
    input  entry_t ent,
    output logic   hit,
    output pc_t    next_pc,
    output logic   is_jump
);
    always_comb begin
        hit     = ent.valid && (ent.tag == tag_of(pc));
        next_pc = hit ? ent.target : seq_pc(pc);
        is_jump = hit && ent.is_jump;
    end
endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
(
    input  resolve_t res,
    input  entry_t   ent_r,
    output wr_req_t  wr,
    output logic     mispredict
);
    logic redirect;
    logic owns;
    pc_t  real_next;

    always_comb begin
        redirect   = res.taken || res.is_jump;
        owns       = ent_r.valid && (ent_r.tag == tag_of(res.pc));
        real_next  = redirect ? res.target : seq_pc(res.pc);
        mispredict = res.valid && (real_next != res.pred_next);

        wr.op           = WR_NONE;
        wr.idx          = idx_of(res.pc);
        wr.data.valid   = 1'b1;
        wr.data.is_jump = res.is_jump;
        wr.data.tag     = tag_of(res.pc);
        wr.data.target  = res.target;
        if (res.valid) begin
            if (redirect)  wr.op = WR_FILL;
            else if (owns) wr.op = WR_KILL;
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            fetch_hit,
    output logic [PC_W-1:0] fetch_next_pc,
    output logic            fetch_is_jump,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_is_jump,
    input  logic [PC_W-1:0] res_target,
    input  logic [PC_W-1:0] res_pred_next,
    output logic            res_mispredict
);
    resolve_t           res;
    wr_req_t            wr;
    entry_t             ent_f;
    entry_t             ent_r;
    logic [ENTRIES-1:0] valid_vec;

    assign res = '{valid: res_valid, pc: res_pc, taken: res_taken,
                   is_jump: res_is_jump, target: res_target,
                   pred_next: res_pred_next};

    btb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_idx_f  (idx_of(fetch_pc)),
        .rd_idx_r  (idx_of(res_pc)),
        .rd_ent_f  (ent_f),
        .rd_ent_r  (ent_r),
        .valid_vec (valid_vec)
    );

    btb_lookup u_lookup (
        .pc      (fetch_pc),
        .ent     (ent_f),
        .hit     (fetch_hit),
        .next_pc (fetch_next_pc),
        .is_jump (fetch_is_jump)
    );

    btb_update u_update (
        .res        (res),
        .ent_r      (ent_r),
        .wr         (wr),
        .mispredict (res_mispredict)
    );

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_hit |-> valid_vec[idx_of(fetch_pc)]);

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(res_valid && (res_taken || res_is_jump)) && (fetch_pc == $past(res_pc)))
        |-> (fetch_hit && fetch_next_pc == $past(res_target)));

    // R10
    taken_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken && !res_mispredict) |-> (res_pred_next == res_target));

    // R10
    idle_no_mp_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_mispredict);
endmodule

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit;
    logic [31:0] fetch_next_pc;
    logic        fetch_is_jump;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_is_jump = 1'b0;
    logic [31:0] res_target = '0;
    logic [31:0] res_pred_next = '0;
    logic        res_mispredict;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        m_v   [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];
    logic        m_j   [16];

    always #5 clk = ~clk;

    btb_predictor u_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
        .fetch_next_pc(fetch_next_pc), .fetch_is_jump(fetch_is_jump),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_is_jump(res_is_jump), .res_target(res_target),
        .res_pred_next(res_pred_next), .res_mispredict(res_mispredict)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    // one cycle: drive, compare with the model before the edge, update the model after it
    task automatic cyc(input string r, input logic [31:0] fpc,
                       input logic rv, input logic [31:0] rpc, input logic rt,
                       input logic rj, input logic [31:0] rtg, input logic [31:0] rpn);
        int fi;
        int ri;
        logic eh;
        logic [31:0] en;
        logic [31:0] act_next;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
        res_is_jump = rj; res_target = rtg; res_pred_next = rpn;
        #2;
        fi = int'((fpc >> 2) & 32'hF);
        eh = m_v[fi] && (m_tag[fi] == fpc[31:6]);
        en = eh ? m_tgt[fi] : fpc + 32'd4;
        chk({r, " hit"}, {31'd0, fetch_hit}, {31'd0, eh});
        chk({r, " next"}, fetch_next_pc, en);
        chk("R11 jump flag", {31'd0, fetch_is_jump}, {31'd0, eh && m_j[fi]});
        act_next = (rt || rj) ? rtg : rpc + 32'd4;
        chk("R10 mispredict", {31'd0, res_mispredict}, {31'd0, rv && (act_next != rpn)});
        @(posedge clk);
        ri = int'((rpc >> 2) & 32'hF);
        if (rv) begin
            if (rt || rj) begin
                m_v[ri] = 1'b1; m_tag[ri] = rpc[31:6]; m_tgt[ri] = rtg; m_j[ri] = rj;
            end else if (m_v[ri] && m_tag[ri] == rpc[31:6]) begin
                m_v[ri] = 1'b0;
            end
        end
    endtask

    task automatic fetch_only(input string r, input logic [31:0] fpc);
        cyc(r, fpc, 1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 32'd0);
    endtask

    localparam logic [31:0] A = 32'h0000_1040;
    localparam logic [31:0] B = 32'h0000_2040; // same index as A, other tag
    localparam logic [31:0] J = 32'h0000_3008;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_j[i] = 1'b0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: everything misses after reset
        fetch_only("R1", 32'h0000_0100);
        fetch_only("R1", A);
        // R4 and R10: taken branch allocates, predicted sequential so mispredict
        cyc("R4", 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h2000, A + 32'd4);
        fetch_only("R3", A);
        chk("R3 target", fetch_next_pc, 32'h2000);
        fetch_only("R2", A + 32'd4);
        // R8: aliasing address misses
        fetch_only("R8", B);
        // R7: not-taken resolve of alias leaves A intact
        cyc("R7", A, 1'b1, B, 1'b0, 1'b0, 32'h5000, B + 32'd4);
        fetch_only("R7", A);
        chk("R7 kept", {31'd0, fetch_hit}, 32'd1);
        // R5 and R11: jump with taken low still allocates
        cyc("R5", J, 1'b1, J, 1'b0, 1'b1, 32'h4000, J + 32'd4);
        fetch_only("R5", J);
        chk("R5 hit", {31'd0, fetch_hit}, 32'd1);
        chk("R11 flag", {31'd0, fetch_is_jump}, 32'd1);
        // R9: retarget in place
        cyc("R9", 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h2400, 32'h2000);
        fetch_only("R9", A);
        chk("R9 target", fetch_next_pc, 32'h2400);
        // R10: correct prediction, no mispredict
        cyc("R10", 32'h0, 1'b1, A, 1'b1, 1'b0, 32'h2400, 32'h2400);
        // R6: not-taken resolve with a hit clears the entry
        cyc("R6", 32'h0, 1'b1, A, 1'b0, 1'b0, 32'h2400, 32'h2400);
        fetch_only("R6", A);
        chk("R6 miss", {31'd0, fetch_hit}, 32'd0);
        // R13: same-cycle fetch sees old contents, next cycle sees new
        cyc("R13", A, 1'b1, A, 1'b1, 1'b0, 32'h2800, A + 32'd4);
        fetch_only("R13", A);
        // R12: eviction by another tag
        cyc("R12", A, 1'b1, B, 1'b1, 1'b0, 32'h6000, B + 32'd4);
        fetch_only("R12", A);
        chk("R12 evicted", {31'd0, fetch_hit}, 32'd0);
        fetch_only("R12", B);
        chk("R12 new", fetch_next_pc, 32'h6000);
        // mixed traffic against the model
        for (int k = 0; k < 300; k++) begin
            logic [31:0] fp;
            logic [31:0] rp;
            fp = {20'h0, 4'($urandom_range(0, 3)), 6'($urandom_range(0, 63)), 2'b00};
            rp = {20'h0, 4'($urandom_range(0, 3)), 6'($urandom_range(0, 63)), 2'b00};
            cyc("R3", fp, 1'($urandom), rp, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                {16'h0, 16'($urandom)} & 32'hFFFF_FFFC,
                ($urandom_range(0, 1) == 0) ? rp + 32'd4 : {16'h0, 16'($urandom)});
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule